// File: doc/BRIEF.md
# Prioritised Vectored Interrupt Controller

This block collects interrupt requests from a CPU's surroundings and hands the core one vector address at a time. It handles fifteen maskable sources, a software break and reset. Each maskable source has a request latch and an enable bit. Five external pins are synchronised and then edge-detected, with the active edge chosen per pin. A key-input slot fires when the AND of all key pins falls. One slot is shared between a trigger pin's falling edge and a conversion-done pulse. The remaining eight slots take single-cycle pulses from internal peripherals.

Every pending source has a fixed position in one 17-entry priority order: reset at index 0, the maskable slots at indices 1 to 15, and the break at index 16. The winner is captured into a holding register and shown to the CPU with `irqReq`. The vector low-byte address is `0xFFFC - 2*index`, and the high byte sits one address above it. A single-cycle acknowledge clears the accepted source and causes a one-cycle `setIFlag` pulse that the core uses to raise its global disable flag. Software reads and writes the request, enable and edge-select registers through a simple register port.

Top module: `vec_irq_ctrl`

## Requirements
- R1: After reset the request and enable registers read 0, the edge register reads 0x001F, and the block presents index 0 with vector 0xFFFC whatever the value of `iFlag`.
- R2: A maskable slot s (index s+1) is presented only while its request bit is 1, its enable bit is 1 and `iFlag` is 0.
- R3: Register address 0 holds the request bits; writing 0 to a bit clears it and writing 1 leaves it unchanged. Address 1 holds the enable bits, and software can write them to either value.
- R4: When several sources are pending, the lowest index wins. The vector is 0xFFFC minus twice the index, so the break at index 16 uses 0xFFDC.
- R5: A break request is taken with `iFlag` set and all enable bits 0.
- R6: An acknowledge while `irqReq` is high clears the accepted source's request and gives a one-cycle `setIFlag` pulse in the next cycle.
- R7: Pin i drives slot i (i in 0..4). Edge register bit i set to 1 selects the rising edge and 0 selects the falling edge; the other edge is ignored. The request bit becomes readable after the third clock edge that follows the pin change.
- R8: Changing an edge-select bit so that the pin's current level counts as active sets that slot's request. Changing it the other way sets nothing, and once the spurious bit has been cleared it stays clear.
- R9: Slot 5 is set when the AND of all key pins falls. A further key going low while another key is already low sets nothing.
- R10: Slot 6 takes the trigger pin's falling edge when edge register bit 15 is 0 and the `convDone` pulse when it is 1. The unselected event is ignored.
- R11: Internal event pulse k sets request slot 7+k at the next clock edge.
- R12: The vector and index stay stable while `irqReq` is high. If the held source stops qualifying before it is acknowledged, the block withdraws `irqReq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| extPin | input | 5 | Edge-triggered external pins |
| keyPins | input | 8 | Key input levels, idle high |
| trigPin | input | 1 | External trigger pin, idle high |
| convDone | input | 1 | Conversion-complete pulse |
| intEvt | input | 8 | Internal peripheral event pulses |
| brkReq | input | 1 | Software break pulse from the core |
| iFlag | input | 1 | Core's global interrupt-disable flag |
| ackPulse | input | 1 | Single-cycle acknowledge from the core |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 2 | Register address |
| regWData | input | 16 | Register write data |
| regRData | output | 16 | Register read data |
| irqReq | output | 1 | A source is presented to the core |
| vecAddr | output | 16 | Vector low-byte address of the presented source |
| srcIdx | output | 5 | Priority index of the presented source |
| setIFlag | output | 1 | One-cycle pulse telling the core to set its disable flag |

## Verification
Single internal pulses are tried against each combination of enable bit and disable flag, which separates masking by the enable bit from masking by the flag. Two pulses are fired in the same cycle, and a break is fired together with a maskable pulse, so that the order of service tells whether the priority order and the vector arithmetic hold at both ends. Pin levels are stepped under both edge selections and under edge-select rewrites with the pin held still, which separates real edges from the spurious set and from ignored edges. Key, trigger and conversion stimuli are applied under both shared-slot selections to show which event owns the slot.

// File: rtl/vic_pkg.sv
package vic_pkg;
  typedef struct packed {
    logic capture;
    logic accept;
    logic drop;
  } vic_strobe_t;

  typedef enum logic [1:0] {
    REG_REQ  = 2'd0,
    REG_EN   = 2'd1,
    REG_EDGE = 2'd2
  } vic_reg_e;
endpackage

// File: rtl/vic_prio_enc.sv
module vic_prio_enc #(
  parameter int N  = 17,
  parameter int IW = 5
) (
  input  logic [N-1:0]  cand,
  output logic [IW-1:0] idx,
  output logic          any
);
  always_comb begin
    idx = '0;
    any = |cand;
    for (int i = N - 1; i >= 0; i--) begin
      if (cand[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/vic_control.sv
module vic_control
  import vic_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        anyCand,
  input  logic        heldValid,
  input  logic        ackPulse,
  output vic_strobe_t strobes,
  output logic        presenting
);
  typedef enum logic {ST_IDLE, ST_SHOW} state_e;
  state_e state;

  always_comb begin
    strobes = '0;
    case (state)
      ST_IDLE: strobes.capture = anyCand;
      ST_SHOW: begin
        if (ackPulse)        strobes.accept = 1'b1;
        else if (!heldValid) strobes.drop   = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else if (strobes.capture) state <= ST_SHOW;
    else if (strobes.accept || strobes.drop) state <= ST_IDLE;
  end

  assign presenting = (state == ST_SHOW);
endmodule

// File: rtl/vic_datapath.sv
module vic_datapath
  import vic_pkg::*;
#(
  parameter int          NUM_EXT = 5,
  parameter int          KEY_W   = 8,
  parameter int          NUM_INT = 8,
  parameter logic [15:0] RST_VEC = 16'hFFFC,
  localparam int NUM_MASK = NUM_EXT + 2 + NUM_INT,
  localparam int TOT      = NUM_MASK + 2,
  localparam int IDX_W    = $clog2(TOT)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_EXT-1:0] extPin,
  input  logic [KEY_W-1:0]   keyPins,
  input  logic               trigPin,
  input  logic               convDone,
  input  logic [NUM_INT-1:0] intEvt,
  input  logic               brkReq,
  input  logic               iFlag,
  input  logic               regWr,
  input  logic [1:0]         regAddr,
  input  logic [15:0]        regWData,
  output logic [15:0]        regRData,
  input  vic_strobe_t        strobes,
  output logic               anyCand,
  output logic               heldValid,
  output logic [15:0]        vecAddr,
  output logic [IDX_W-1:0]   srcIdx,
  output logic               setIFlag
);
  localparam int KEY_SLOT = NUM_EXT;
  localparam int SH_SLOT  = NUM_EXT + 1;
  localparam int INT_BASE = NUM_EXT + 2;
  localparam int BRK_IDX  = TOT - 1;

  // pin synchronisers and edge detection
  logic [NUM_EXT-1:0] pinS1, pinS2, pinLvlQ, pinLvl, pinHit;
  logic [NUM_EXT-1:0] edgeSel;
  logic               shSel;

  genvar g;
  generate
    for (g = 0; g < NUM_EXT; g++) begin : g_pin
      // selecting the other edge flips the normalised level, which may look like an edge
      assign pinLvl[g] = pinS2[g] ~^ edgeSel[g];
      assign pinHit[g] = pinLvl[g] & ~pinLvlQ[g];
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pinS1   <= '0;
      pinS2   <= '0;
      pinLvlQ <= '0;
    end else begin
      pinS1   <= extPin;
      pinS2   <= pinS1;
      pinLvlQ <= pinLvl;
    end
  end

  // key input: falling edge of the AND of all key levels
  logic [KEY_W-1:0] keyS1, keyS2;
  logic keyAll, keyAllQ, keyHit;
  assign keyAll = &keyS2;
  assign keyHit = keyAllQ & ~keyAll;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      keyS1   <= '1;
      keyS2   <= '1;
      keyAllQ <= 1'b1;
    end else begin
      keyS1   <= keyPins;
      keyS2   <= keyS1;
      keyAllQ <= keyAll;
    end
  end

  // shared slot: trigger falling edge or conversion done
  logic trigS1, trigS2, shSig, shSigQ, shHit;
  assign shSig = shSel ? convDone : ~trigS2;
  assign shHit = shSig & ~shSigQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      trigS1 <= 1'b1;
      trigS2 <= 1'b1;
      shSigQ <= 1'b0;
    end else begin
      trigS1 <= trigPin;
      trigS2 <= trigS1;
      shSigQ <= shSig;
    end
  end

  // request set vector
  logic [NUM_MASK-1:0] setVec;
  always_comb begin
    setVec                          = '0;
    setVec[NUM_EXT-1:0]             = pinHit;
    setVec[KEY_SLOT]                = keyHit;
    setVec[SH_SLOT]                 = shHit;
    setVec[NUM_MASK-1:INT_BASE]     = intEvt;
  end

  // request, enable and edge registers
  logic [NUM_MASK-1:0] reqQ, enQ, swClr, ackClr;
  logic [IDX_W-1:0]    heldIdx;
  logic                rstPend, brkPend;
  logic                wrReq, wrEn, wrEdge;

  assign wrReq  = regWr && (regAddr == REG_REQ);
  assign wrEn   = regWr && (regAddr == REG_EN);
  assign wrEdge = regWr && (regAddr == REG_EDGE);
  assign swClr  = wrReq ? ~regWData[NUM_MASK-1:0] : '0;

  generate
    for (g = 0; g < NUM_MASK; g++) begin : g_ack
      assign ackClr[g] = strobes.accept && (heldIdx == IDX_W'(g + 1));
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqQ    <= '0;
      enQ     <= '0;
      edgeSel <= '1;
      shSel   <= 1'b0;
    end else begin
      reqQ <= (reqQ & ~swClr & ~ackClr) | setVec;
      if (wrEn) enQ <= regWData[NUM_MASK-1:0];
      if (wrEdge) begin
        edgeSel <= regWData[NUM_EXT-1:0];
        shSel   <= regWData[15];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rstPend <= 1'b1;
      brkPend <= 1'b0;
    end else begin
      if (strobes.accept && heldIdx == '0) rstPend <= 1'b0;
      brkPend <= (brkPend & ~(strobes.accept && heldIdx == IDX_W'(BRK_IDX))) | brkReq;
    end
  end

  // arbitration
  logic [NUM_MASK-1:0] maskCand;
  logic [TOT-1:0]      cand;
  logic [IDX_W-1:0]    winIdx;

  assign maskCand = reqQ & enQ & {NUM_MASK{~iFlag}};
  assign cand     = {brkPend, maskCand, rstPend};

  vic_prio_enc #(.N(TOT), .IW(IDX_W)) u_enc (
    .cand (cand),
    .idx  (winIdx),
    .any  (anyCand)
  );

  // holding registers for the presented source
  logic [15:0] vecQ;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      heldIdx  <= '0;
      vecQ     <= RST_VEC;
      setIFlag <= 1'b0;
    end else begin
      if (strobes.capture) begin
        heldIdx <= winIdx;
        vecQ    <= RST_VEC - 16'({winIdx, 1'b0});
      end
      setIFlag <= strobes.accept;
    end
  end

  assign heldValid = (heldIdx < IDX_W'(TOT)) && cand[heldIdx];
  assign vecAddr   = vecQ;
  assign srcIdx    = heldIdx;

  // register read
  always_comb begin
    regRData = '0;
    case (regAddr)
      REG_REQ:  regRData[NUM_MASK-1:0] = reqQ;
      REG_EN:   regRData[NUM_MASK-1:0] = enQ;
      REG_EDGE: begin
        regRData[NUM_EXT-1:0] = edgeSel;
        regRData[15]          = shSel;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl
  import vic_pkg::*;
#(
  parameter int          NUM_EXT = 5,
  parameter int          KEY_W   = 8,
  parameter int          NUM_INT = 8,
  parameter logic [15:0] RST_VEC = 16'hFFFC,
  localparam int NUM_MASK = NUM_EXT + 2 + NUM_INT,
  localparam int IDX_W    = $clog2(NUM_MASK + 2)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_EXT-1:0] extPin,
  input  logic [KEY_W-1:0]   keyPins,
  input  logic               trigPin,
  input  logic               convDone,
  input  logic [NUM_INT-1:0] intEvt,
  input  logic               brkReq,
  input  logic               iFlag,
  input  logic               ackPulse,
  input  logic               regWr,
  input  logic [1:0]         regAddr,
  input  logic [15:0]        regWData,
  output logic [15:0]        regRData,
  output logic               irqReq,
  output logic [15:0]        vecAddr,
  output logic [IDX_W-1:0]   srcIdx,
  output logic               setIFlag
);
  vic_strobe_t strobes;
  logic anyCand, heldValid;

  vic_control u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .anyCand    (anyCand),
    .heldValid  (heldValid),
    .ackPulse   (ackPulse),
    .strobes    (strobes),
    .presenting (irqReq)
  );

  vic_datapath #(
    .NUM_EXT (NUM_EXT),
    .KEY_W   (KEY_W),
    .NUM_INT (NUM_INT),
    .RST_VEC (RST_VEC)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .extPin    (extPin),
    .keyPins   (keyPins),
    .trigPin   (trigPin),
    .convDone  (convDone),
    .intEvt    (intEvt),
    .brkReq    (brkReq),
    .iFlag     (iFlag),
    .regWr     (regWr),
    .regAddr   (regAddr),
    .regWData  (regWData),
    .regRData  (regRData),
    .strobes   (strobes),
    .anyCand   (anyCand),
    .heldValid (heldValid),
    .vecAddr   (vecAddr),
    .srcIdx    (srcIdx),
    .setIFlag  (setIFlag)
  );
endmodule

// File: rtl/vec_irq_ctrl_chk.sv
module vec_irq_ctrl_chk #(
  parameter int          NUM_MASK = 15,
  parameter int          IDX_W    = 5,
  parameter logic [15:0] RST_VEC  = 16'hFFFC
) (
  input logic             clk,
  input logic             rstN,
  input logic             irqReq,
  input logic             ackPulse,
  input logic             setIFlag,
  input logic             iFlag,
  input logic [15:0]      vecAddr,
  input logic [IDX_W-1:0] srcIdx
);
  localparam logic [15:0] LOW_VEC = RST_VEC - 16'(2 * (NUM_MASK + 1));

  // R12
  vec_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqReq && $past(irqReq) |-> $stable(vecAddr) && $stable(srcIdx));

  // R4
  vec_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqReq |-> (vecAddr[0] == 1'b0) && (vecAddr >= LOW_VEC) && (vecAddr <= RST_VEC));

  // R6
  ack_iflag_chk: assert property (@(posedge clk) disable iff (!rstN)
    ackPulse && irqReq |=> setIFlag);

  // R6
  iflag_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    setIFlag |-> $past(ackPulse && irqReq));

  // R2
  mask_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqReq && $past(irqReq) && (srcIdx != '0) && (srcIdx <= IDX_W'(NUM_MASK)) |-> !$past(iFlag));
endmodule

bind vec_irq_ctrl vec_irq_ctrl_chk #(
  .NUM_MASK (NUM_MASK),
  .IDX_W    (IDX_W),
  .RST_VEC  (RST_VEC)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .irqReq   (irqReq),
  .ackPulse (ackPulse),
  .setIFlag (setIFlag),
  .iFlag    (iFlag),
  .vecAddr  (vecAddr),
  .srcIdx   (srcIdx)
);

// File: tb/test_vec_irq_ctrl.sv
module test_vec_irq_ctrl;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rstN;
  logic [4:0]  extPin;
  logic [7:0]  keyPins;
  logic        trigPin, convDone, brkReq, iFlag, ackPulse, regWr;
  logic [7:0]  intEvt;
  logic [1:0]  regAddr;
  logic [15:0] regWData, regRData, vecAddr;
  logic        irqReq, setIFlag;
  logic [4:0]  srcIdx;

  int nChk = 0;
  int nFail = 0;
  bit finished = 1'b0;

  vec_irq_ctrl i_vec_irq_ctrl (
    .clk(clk), .rstN(rstN), .extPin(extPin), .keyPins(keyPins),
    .trigPin(trigPin), .convDone(convDone), .intEvt(intEvt), .brkReq(brkReq),
    .iFlag(iFlag), .ackPulse(ackPulse), .regWr(regWr), .regAddr(regAddr),
    .regWData(regWData), .regRData(regRData), .irqReq(irqReq),
    .vecAddr(vecAddr), .srcIdx(srcIdx), .setIFlag(setIFlag)
  );

  task automatic chkEq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic regWrite(input logic [1:0] a, input logic [15:0] d);
    regAddr = a; regWData = d; regWr = 1'b1;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic regRead(input logic [1:0] a, output logic [15:0] d);
    regAddr = a;
    #1;
    d = regRData;
  endtask

  task automatic pulseInt(input int k);
    intEvt[k] = 1'b1;
    @(negedge clk);
    intEvt = '0;
  endtask

  // wait for a presented source, check it, acknowledge, check the flag pulse
  task automatic serve(input string tag, input int expIdx);
    for (int i = 0; i < 10 && !irqReq; i++) @(negedge clk);
    chkEq({tag, " irqReq"}, irqReq, 1);
    chkEq({tag, " srcIdx"}, srcIdx, expIdx);
    chkEq({tag, " vecAddr"}, vecAddr, 16'hFFFC - 16'(2 * expIdx));
    ackPulse = 1'b1;
    @(negedge clk);
    ackPulse = 1'b0;
    chkEq({tag, " R6 setIFlag high"}, setIFlag, 1);
    @(negedge clk);
    chkEq({tag, " R6 setIFlag low"}, setIFlag, 0);
  endtask

  task automatic testReset();
    logic [15:0] d;
    regRead(2'd0, d); chkEq("R1 req reset", d, 16'h0000);
    regRead(2'd1, d); chkEq("R1 en reset", d, 16'h0000);
    regRead(2'd2, d); chkEq("R1 edge reset", d, 16'h001F);
    serve("R1 reset vector", 0);
    chkEq("R1 irq after ack", irqReq, 0);
  endtask

  task automatic testMask();
    logic [15:0] d;
    pulseInt(0);
    tick(1);
    regRead(2'd0, d); chkEq("R11 event sets slot 7", d, 16'h0080);
    chkEq("R2 disabled not shown", irqReq, 0);
    iFlag = 1'b1;
    regWrite(2'd1, 16'h0080);
    tick(3);
    chkEq("R2 flag masks", irqReq, 0);
    iFlag = 1'b0;
    serve("R2 enabled shown", 8);
    regRead(2'd0, d); chkEq("R6 request cleared by ack", d, 16'h0000);
    regWrite(2'd1, 16'h0000);
  endtask

  task automatic testSwWrite();
    logic [15:0] d;
    regWrite(2'd0, 16'h7FFF);
    regRead(2'd0, d); chkEq("R3 write 1 cannot set", d, 16'h0000);
    pulseInt(1);
    regWrite(2'd0, 16'h7FFF);
    regRead(2'd0, d); chkEq("R3 write 1 keeps bit", d, 16'h0100);
    regWrite(2'd0, 16'hFEFF);
    regRead(2'd0, d); chkEq("R3 write 0 clears", d, 16'h0000);
    iFlag = 1'b1;
    regWrite(2'd1, 16'h1234);
    regRead(2'd1, d); chkEq("R3 enable write", d, 16'h1234);
    regWrite(2'd1, 16'h0000);
    regRead(2'd1, d); chkEq("R3 enable clear", d, 16'h0000);
    iFlag = 1'b0;
  endtask

  task automatic testPrio();
    regWrite(2'd1, 16'h1200);
    intEvt[2] = 1'b1; intEvt[5] = 1'b1;
    @(negedge clk);
    intEvt = '0;
    serve("R4 higher first", 10);
    serve("R4 lower second", 13);
    regWrite(2'd1, 16'h0000);
  endtask

  task automatic testBreak();
    iFlag = 1'b1;
    brkReq = 1'b1; @(negedge clk); brkReq = 1'b0;
    serve("R5 break unmaskable", 16);
    iFlag = 1'b0;
    regWrite(2'd1, 16'h4000);
    brkReq = 1'b1; intEvt[7] = 1'b1;
    @(negedge clk);
    brkReq = 1'b0; intEvt = '0;
    serve("R4 maskable before break", 15);
    serve("R4 break last", 16);
    regWrite(2'd1, 16'h0000);
  endtask

  task automatic testEdge();
    logic [15:0] d;
    extPin[1] = 1'b1;
    tick(2);
    regRead(2'd0, d); chkEq("R7 not yet after two edges", d, 16'h0000);
    tick(1);
    regRead(2'd0, d); chkEq("R7 rising sets on third edge", d, 16'h0002);
    regWrite(2'd0, 16'h0000);
    extPin[1] = 1'b0;
    tick(4);
    regRead(2'd0, d); chkEq("R7 falling ignored in rising mode", d, 16'h0000);
    regWrite(2'd2, 16'h001D);
    tick(2);
    regRead(2'd0, d); chkEq("R8 edge change sets request", d, 16'h0002);
    regWrite(2'd0, 16'h0000);
    tick(3);
    regRead(2'd0, d); chkEq("R8 cleared stays clear", d, 16'h0000);
    extPin[1] = 1'b1;
    tick(4);
    regRead(2'd0, d); chkEq("R7 rising ignored in falling mode", d, 16'h0000);
    extPin[1] = 1'b0;
    tick(4);
    regRead(2'd0, d); chkEq("R7 falling sets in falling mode", d, 16'h0002);
    regWrite(2'd0, 16'h0000);
    regWrite(2'd2, 16'h001F);
    tick(3);
    regRead(2'd0, d); chkEq("R8 reverse change sets nothing", d, 16'h0000);
  endtask

  task automatic testKey();
    logic [15:0] d;
    keyPins[3] = 1'b0;
    tick(4);
    regRead(2'd0, d); chkEq("R9 key low sets slot 5", d, 16'h0020);
    regWrite(2'd0, 16'h0000);
    keyPins[6] = 1'b0;
    tick(4);
    regRead(2'd0, d); chkEq("R9 second key no new request", d, 16'h0000);
    keyPins = '1;
    tick(4);
    regRead(2'd0, d); chkEq("R9 release no request", d, 16'h0000);
  endtask

  task automatic testShared();
    logic [15:0] d;
    trigPin = 1'b0;
    tick(4);
    regRead(2'd0, d); chkEq("R10 trigger fall sets slot 6", d, 16'h0040);
    regWrite(2'd0, 16'h0000);
    trigPin = 1'b1;
    tick(3);
    convDone = 1'b1; @(negedge clk); convDone = 1'b0;
    tick(1);
    regRead(2'd0, d); chkEq("R10 convDone ignored when unselected", d, 16'h0000);
    regWrite(2'd2, 16'h801F);
    tick(1);
    convDone = 1'b1; @(negedge clk); convDone = 1'b0;
    tick(1);
    regRead(2'd0, d); chkEq("R10 convDone sets when selected", d, 16'h0040);
    regWrite(2'd0, 16'h0000);
    trigPin = 1'b0;
    tick(4);
    regRead(2'd0, d); chkEq("R10 trigger ignored when unselected", d, 16'h0000);
    trigPin = 1'b1;
    tick(3);
    regWrite(2'd2, 16'h001F);
    tick(2);
  endtask

  task automatic testWithdraw();
    logic [4:0]  idx0;
    logic [15:0] vec0;
    regWrite(2'd1, 16'h0400);
    pulseInt(3);
    for (int i = 0; i < 10 && !irqReq; i++) @(negedge clk);
    idx0 = srcIdx; vec0 = vecAddr;
    chkEq("R12 shown index", idx0, 11);
    tick(3);
    chkEq("R12 index held", srcIdx, idx0);
    chkEq("R12 vector held", vecAddr, vec0);
    regWrite(2'd0, 16'h0000);
    tick(2);
    chkEq("R12 withdrawn after clear", irqReq, 0);
    regWrite(2'd1, 16'h0000);
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChk++;
    nFail++;
    $display("FAIL watchdog expired actual=%0h expected=%0h", 0, 1);
    finishRun();
  end

  initial begin
    rstN = 1'b0; extPin = '0; keyPins = '1; trigPin = 1'b1; convDone = 1'b0;
    intEvt = '0; brkReq = 1'b0; iFlag = 1'b1; ackPulse = 1'b0;
    regWr = 1'b0; regAddr = '0; regWData = '0;
    tick(3);
    rstN = 1'b1;
    testReset();
    iFlag = 1'b0;
    testMask();
    testSwWrite();
    testPrio();
    testBreak();
    testEdge();
    testKey();
    testShared();
    testWithdraw();
    finishRun();
  end
endmodule